// File: doc/BRIEF.md
# Adaptive Counter Tree Activation Tracker

This block watches the stream of row activations into one DRAM bank and decides when the neighbours of a heavily used row region need a preventive refresh. It has a small pool of counters. The pool starts as one counter that covers the whole bank. Counters are then handed to the address ranges that take the most traffic, so a hot region ends up tracked at fine grain while a cold region stays coarse.

The regions form a binary tree. Internal nodes split an address range in two. Leaves are counters. For each access the block walks the tree from the root, one node per clock. It increments the leaf it reaches and returns that leaf's index, its new count and its depth. A leaf that reaches half the refresh threshold turns into an internal node with two child counters, as long as the pool and the depth limit allow it. A leaf that reaches the full threshold produces a burst of refresh row requests and is then cleared. A pulse at the end of each refresh window collapses the tree back to a single root counter.

Top module: `ctr_tree_tracker`

## Requirements
- R1: After reset, one leaf covers all 2^ROW_W rows. That leaf is counter 0 at depth 0 with a count of 0, so the first access responds with leaf 0, count 1, depth 0.
- R2: `acc_ready_o` is high only when the block is idle. Every accepted access produces exactly one `rsp_valid_o` pulse, and no access is accepted while refresh requests are still being issued.
- R3: At depth d the walk reads row bit (ROW_W-1-d). A value of 0 selects the child covering the lower half of the range and 1 selects the upper half. `rsp_depth_o` reports the depth of the leaf that was reached.
- R4: Each access adds one to the count of its leaf, and `rsp_count_o` reports the incremented value.
- R5: A split happens when the new count equals REF_TH/2, the leaf depth is below MAX_DEPTH and an unused counter exists. The split counter keeps the lower half. The lowest unused index takes the upper half (indices are handed out 1, 2, 3, ...). Both children start at that count, one level deeper.
- R6: A leaf at depth MAX_DEPTH never splits. Its count keeps rising past REF_TH/2.
- R7: Once NUM_CTR counters are in use, no further split happens at any depth.
- R8: When the new count equals REF_TH, the response reports REF_TH, that counter is cleared, and the next access to it reports 1.
- R9: When a leaf reaches the full threshold, refresh rows are issued in ascending order, one per cycle while `ref_valid_o` is high. The list is: base-1 if base > 0; every row of the range if its span is at most SMALL_SPAN; base+span if that row is below 2^ROW_W.
- R10: A one-cycle `interval_end_i` collapses the tree to the state described in R1. All counts are cleared and counter allocation restarts at index 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interval_end_i | input | 1 | End of refresh window; rebuilds the tree from the root |
| acc_valid_i | input | 1 | Activation request |
| acc_row_i | input | ROW_W | Activated row address |
| acc_ready_o | output | 1 | Block idle, request may be accepted |
| rsp_valid_o | output | 1 | One-cycle response for an accepted access |
| rsp_leaf_o | output | $clog2(NUM_CTR) | Index of the counter that was hit |
| rsp_count_o | output | $clog2(REF_TH+1) | Count after the increment |
| rsp_depth_o | output | $clog2(MAX_DEPTH+1) | Depth of the leaf that was hit |
| ref_valid_o | output | 1 | Refresh row request valid |
| ref_row_o | output | ROW_W | Row to refresh |

## Verification
The bench builds the block with a 64-row bank, six counters, a depth limit of 3, a threshold of 8 and a small-span limit of 8. With these values a few dozen accesses are enough to split leaves, hit the full threshold several times and reach the depth limit. The pool also runs out while a depth-2 leaf is still available to probe R7. At depth 3 a leaf spans 8 rows, so both the neighbour-only and the whole-range refresh lists appear, including the bottom and top edges of the bank. A software model of the tree predicts every response and every refresh row.

// File: rtl/ctr_tree_pkg.sv
package ctr_tree_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_UPD, ST_REF} trk_state_e;
  typedef enum logic [1:0] {PH_NONE, PH_BELOW, PH_RANGE, PH_ABOVE} ref_phase_e;
endpackage

// File: rtl/ctr_tree_nodes.sv
module ctr_tree_nodes #(
  parameter int unsigned NODE_N = 63,
  parameter int unsigned PTR_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic [PTR_W-1:0] l_ptr_o,
  output logic [PTR_W-1:0] r_ptr_o,
  output logic             l_leaf_o,
  output logic             r_leaf_o,
  input  logic             nw_en_i,
  input  logic [PTR_W-1:0] nw_idx_i,
  input  logic [PTR_W-1:0] nw_l_ptr_i,
  input  logic [PTR_W-1:0] nw_r_ptr_i,
  input  logic             pp_en_i,
  input  logic [PTR_W-1:0] pp_idx_i,
  input  logic             pp_side_i,
  input  logic [PTR_W-1:0] pp_ptr_i
);
  logic [PTR_W-1:0] l_ptr_q [NODE_N];
  logic [PTR_W-1:0] r_ptr_q [NODE_N];
  logic             l_leaf_q [NODE_N];
  logic             r_leaf_q [NODE_N];

  // storage only, validity is tracked by the allocator in the top
  always_ff @(posedge clk_i) begin
    if (nw_en_i) begin
      l_ptr_q[nw_idx_i]  <= nw_l_ptr_i;
      r_ptr_q[nw_idx_i]  <= nw_r_ptr_i;
      l_leaf_q[nw_idx_i] <= 1'b1;
      r_leaf_q[nw_idx_i] <= 1'b1;
    end
    if (pp_en_i) begin
      if (pp_side_i) begin
        r_ptr_q[pp_idx_i]  <= pp_ptr_i;
        r_leaf_q[pp_idx_i] <= 1'b0;
      end else begin
        l_ptr_q[pp_idx_i]  <= pp_ptr_i;
        l_leaf_q[pp_idx_i] <= 1'b0;
      end
    end
  end

  assign l_ptr_o  = l_ptr_q[rd_idx_i];
  assign r_ptr_o  = r_ptr_q[rd_idx_i];
  assign l_leaf_o = l_leaf_q[rd_idx_i];
  assign r_leaf_o = r_leaf_q[rd_idx_i];

  p_patch_distinct_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nw_en_i && pp_en_i) |-> (nw_idx_i != pp_idx_i));
  p_split_children_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nw_en_i |-> (nw_l_ptr_i != nw_r_ptr_i));
endmodule

// File: rtl/ctr_tree_refresh.sv
module ctr_tree_refresh
  import ctr_tree_pkg::*;
#(
  parameter int unsigned ROW_W      = 16,
  parameter int unsigned DEP_W      = 4,
  parameter int unsigned SMALL_SPAN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             start_i,
  input  logic [ROW_W-1:0] base_i,
  input  logic [DEP_W-1:0] depth_i,
  output logic             busy_o,
  output logic             ref_valid_o,
  output logic [ROW_W-1:0] ref_row_o
);
  localparam logic [ROW_W:0] ROWS_N   = (ROW_W+1)'(1) << ROW_W;
  localparam logic [ROW_W:0] SPAN_LIM = (ROW_W+1)'(SMALL_SPAN);

  ref_phase_e     ph_q;
  logic [ROW_W:0] cur_q, base_q, span_q;
  logic [ROW_W:0] st_base, st_span;
  logic           st_small, st_above, cur_small, cur_above;

  assign st_base   = {1'b0, base_i};
  assign st_span   = ROWS_N >> depth_i;
  assign st_small  = st_span <= SPAN_LIM;
  assign st_above  = (st_base + st_span) < ROWS_N;
  assign cur_small = span_q <= SPAN_LIM;
  assign cur_above = (base_q + span_q) < ROWS_N;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_NONE;
      cur_q  <= '0;
      base_q <= '0;
      span_q <= '0;
    end else if (flush_i) begin
      ph_q <= PH_NONE;
    end else if (start_i) begin
      base_q <= st_base;
      span_q <= st_span;
      if (st_base != '0) begin
        ph_q  <= PH_BELOW;
        cur_q <= st_base - 1'b1;
      end else if (st_small) begin
        ph_q  <= PH_RANGE;
        cur_q <= st_base;
      end else if (st_above) begin
        ph_q  <= PH_ABOVE;
        cur_q <= st_base + st_span;
      end else begin
        ph_q  <= PH_NONE;
      end
    end else begin
      case (ph_q)
        PH_BELOW: begin
          if (cur_small) begin
            ph_q  <= PH_RANGE;
            cur_q <= base_q;
          end else if (cur_above) begin
            ph_q  <= PH_ABOVE;
            cur_q <= base_q + span_q;
          end else begin
            ph_q <= PH_NONE;
          end
        end
        PH_RANGE: begin
          if (cur_q == base_q + span_q - 1'b1) begin
            if (cur_above) begin
              ph_q  <= PH_ABOVE;
              cur_q <= cur_q + 1'b1;
            end else begin
              ph_q <= PH_NONE;
            end
          end else begin
            cur_q <= cur_q + 1'b1;
          end
        end
        default: ph_q <= PH_NONE;
      endcase
    end
  end

  assign busy_o      = (ph_q != PH_NONE);
  assign ref_valid_o = busy_o;
  assign ref_row_o   = cur_q[ROW_W-1:0];

  p_ascending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_o && $past(ref_valid_o)) |-> (ref_row_o > $past(ref_row_o)));
  p_start_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/ctr_tree_tracker.sv
module ctr_tree_tracker
  import ctr_tree_pkg::*;
#(
  parameter int unsigned ROW_W      = 16,
  parameter int unsigned NUM_CTR    = 64,
  parameter int unsigned MAX_DEPTH  = 10,
  parameter int unsigned REF_TH     = 16384,
  parameter int unsigned SMALL_SPAN = 4,
  localparam int unsigned CTR_W = $clog2(NUM_CTR),
  localparam int unsigned CNT_W = $clog2(REF_TH + 1),
  localparam int unsigned DEP_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             interval_end_i,
  input  logic             acc_valid_i,
  input  logic [ROW_W-1:0] acc_row_i,
  output logic             acc_ready_o,
  output logic             rsp_valid_o,
  output logic [CTR_W-1:0] rsp_leaf_o,
  output logic [CNT_W-1:0] rsp_count_o,
  output logic [DEP_W-1:0] rsp_depth_o,
  output logic             ref_valid_o,
  output logic [ROW_W-1:0] ref_row_o
);
  localparam logic [CNT_W-1:0] TH_FULL = CNT_W'(REF_TH);
  localparam logic [CNT_W-1:0] TH_HALF = CNT_W'(REF_TH / 2);
  localparam logic [CTR_W:0]   CTR_LIM = (CTR_W+1)'(NUM_CTR);
  localparam logic [DEP_W-1:0] DEP_LIM = DEP_W'(MAX_DEPTH);

  trk_state_e       state_q;
  logic [ROW_W-1:0] row_q;
  logic [CTR_W-1:0] node_q, leaf_q, par_node_q, root_ptr_q, next_node_q;
  logic [CTR_W:0]   next_ctr_q;
  logic [DEP_W-1:0] dep_q;
  logic             par_root_q, par_side_q, root_leaf_q;
  logic [CNT_W-1:0] cnt_q [NUM_CTR];

  logic [CTR_W-1:0] rd_l_ptr, rd_r_ptr, child_ptr;
  logic             rd_l_leaf, rd_r_leaf, sel, child_leaf;
  logic [ROW_W-1:0] row_sh, base_mask, leaf_base;
  logic [CNT_W-1:0] new_cnt;
  logic             hit_full, do_split, ref_busy;

  assign row_sh     = row_q >> ((ROW_W - 1) - 32'(dep_q));
  assign sel        = row_sh[0];
  assign child_ptr  = sel ? rd_r_ptr : rd_l_ptr;
  assign child_leaf = sel ? rd_r_leaf : rd_l_leaf;
  assign base_mask  = ~({ROW_W{1'b1}} >> dep_q);
  assign leaf_base  = row_q & base_mask;

  assign new_cnt  = cnt_q[leaf_q] + CNT_W'(1);
  assign hit_full = (state_q == ST_UPD) && (new_cnt == TH_FULL);
  assign do_split = (state_q == ST_UPD) && !hit_full && (new_cnt == TH_HALF)
                  && (dep_q < DEP_LIM) && (next_ctr_q < CTR_LIM);

  ctr_tree_nodes #(.NODE_N(NUM_CTR - 1), .PTR_W(CTR_W)) u_nodes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (node_q),
    .l_ptr_o    (rd_l_ptr),
    .r_ptr_o    (rd_r_ptr),
    .l_leaf_o   (rd_l_leaf),
    .r_leaf_o   (rd_r_leaf),
    .nw_en_i    (do_split),
    .nw_idx_i   (next_node_q),
    .nw_l_ptr_i (leaf_q),
    .nw_r_ptr_i (next_ctr_q[CTR_W-1:0]),
    .pp_en_i    (do_split && !par_root_q),
    .pp_idx_i   (par_node_q),
    .pp_side_i  (par_side_q),
    .pp_ptr_i   (next_node_q)
  );

  ctr_tree_refresh #(.ROW_W(ROW_W), .DEP_W(DEP_W), .SMALL_SPAN(SMALL_SPAN)) u_ref (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (interval_end_i),
    .start_i     (hit_full),
    .base_i      (leaf_base),
    .depth_i     (dep_q),
    .busy_o      (ref_busy),
    .ref_valid_o (ref_valid_o),
    .ref_row_o   (ref_row_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      row_q       <= '0;
      node_q      <= '0;
      leaf_q      <= '0;
      dep_q       <= '0;
      par_root_q  <= 1'b1;
      par_node_q  <= '0;
      par_side_q  <= 1'b0;
      root_leaf_q <= 1'b1;
      root_ptr_q  <= '0;
      next_ctr_q  <= (CTR_W+1)'(1);
      next_node_q <= '0;
      for (int i = 0; i < NUM_CTR; i++) cnt_q[i] <= '0;
    end else if (interval_end_i) begin
      state_q     <= ST_IDLE;
      root_leaf_q <= 1'b1;
      root_ptr_q  <= '0;
      next_ctr_q  <= (CTR_W+1)'(1);
      next_node_q <= '0;
      for (int i = 0; i < NUM_CTR; i++) cnt_q[i] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (acc_valid_i) begin
          row_q      <= acc_row_i;
          dep_q      <= '0;
          par_root_q <= 1'b1;
          if (root_leaf_q) begin
            leaf_q  <= root_ptr_q;
            state_q <= ST_UPD;
          end else begin
            node_q  <= root_ptr_q;
            state_q <= ST_WALK;
          end
        end
        ST_WALK: begin
          dep_q      <= dep_q + 1'b1;
          par_root_q <= 1'b0;
          par_node_q <= node_q;
          par_side_q <= sel;
          if (child_leaf) begin
            leaf_q  <= child_ptr;
            state_q <= ST_UPD;
          end else begin
            node_q  <= child_ptr;
          end
        end
        ST_UPD: begin
          cnt_q[leaf_q] <= hit_full ? '0 : new_cnt;
          if (do_split) begin
            cnt_q[next_ctr_q[CTR_W-1:0]] <= new_cnt;
            next_ctr_q  <= next_ctr_q + 1'b1;
            next_node_q <= next_node_q + 1'b1;
            if (par_root_q) begin
              root_leaf_q <= 1'b0;
              root_ptr_q  <= next_node_q;
            end
          end
          state_q <= hit_full ? ST_REF : ST_IDLE;
        end
        default: if (!ref_busy) state_q <= ST_IDLE;
      endcase
    end
  end

  assign acc_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_UPD);
  assign rsp_leaf_o  = leaf_q;
  assign rsp_count_o = new_cnt;
  assign rsp_depth_o = dep_q;

  p_alloc_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_ctr_q <= CTR_LIM);
  p_depth_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_depth_o <= DEP_LIM));
  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_count_o != '0 && rsp_count_o <= TH_FULL));
  p_clear_after_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_count_o == TH_FULL) |=> (cnt_q[leaf_q] == '0));
  p_no_accept_in_refresh_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_o |-> !acc_ready_o);
  p_interval_rebuild_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interval_end_i |=> (root_leaf_q && acc_ready_o && next_ctr_q == (CTR_W+1)'(1)));
endmodule

// File: tb/sim_ctr_tree_tracker.sv
`timescale 1ns/1ps
module sim_ctr_tree_tracker;
  localparam int RW = 6, NC = 6, MD = 3, TH = 8, SS = 8;

  logic          clk = 1'b0, rst_n = 1'b0, iv_end = 1'b0, a_valid = 1'b0;
  logic [RW-1:0] a_row = '0;
  logic          a_ready, r_valid, f_valid;
  logic [2:0]    r_leaf;
  logic [3:0]    r_cnt;
  logic [1:0]    r_dep;
  logic [RW-1:0] f_row;

  ctr_tree_tracker #(.ROW_W(RW), .NUM_CTR(NC), .MAX_DEPTH(MD), .REF_TH(TH), .SMALL_SPAN(SS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .interval_end_i(iv_end),
    .acc_valid_i(a_valid), .acc_row_i(a_row), .acc_ready_o(a_ready),
    .rsp_valid_o(r_valid), .rsp_leaf_o(r_leaf), .rsp_count_o(r_cnt), .rsp_depth_o(r_dep),
    .ref_valid_o(f_valid), .ref_row_o(f_row)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int q_leaf[$], q_cnt[$], q_dep[$], q_ref[$];
  int m_base[NC], m_dep[NC], m_cnt[NC];
  int m_used;
  int last_leaf, last_cnt, last_dep;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_used = 1; m_base[0] = 0; m_dep[0] = 0;
    for (int i = 0; i < NC; i++) m_cnt[i] = 0;
  endtask

  // model predicts, pushes expectations, then drives one access
  task automatic acc(int row);
    int c = 0;
    int span, nc;
    for (int i = 0; i < m_used; i++) begin
      span = (1 << RW) >> m_dep[i];
      if (row >= m_base[i] && row < m_base[i] + span) c = i;
    end
    span = (1 << RW) >> m_dep[c];
    nc = m_cnt[c] + 1;
    q_leaf.push_back(c); q_cnt.push_back(nc); q_dep.push_back(m_dep[c]);
    if (nc == TH) begin
      if (m_base[c] > 0) q_ref.push_back(m_base[c] - 1);
      if (span <= SS) for (int r = 0; r < span; r++) q_ref.push_back(m_base[c] + r);
      if (m_base[c] + span < (1 << RW)) q_ref.push_back(m_base[c] + span);
      m_cnt[c] = 0;
    end else if (nc == TH / 2 && m_dep[c] < MD && m_used < NC) begin
      m_dep[c]++;
      m_dep[m_used] = m_dep[c];
      m_base[m_used] = m_base[c] + span / 2;
      m_cnt[m_used] = nc;
      m_cnt[c] = nc;
      m_used++;
    end else begin
      m_cnt[c] = nc;
    end
    while (!a_ready) @(negedge clk);
    a_valid = 1'b1; a_row = RW'(row);
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!a_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) if (rst_n) begin
    if (r_valid) begin
      if (q_leaf.size() == 0) chk("R2 unexpected response", 1, 0);
      else begin
        chk("R5 leaf index", int'(r_leaf), q_leaf.pop_front());
        chk("R4 count", int'(r_cnt), q_cnt.pop_front());
        chk("R3 depth", int'(r_dep), q_dep.pop_front());
      end
      last_leaf = int'(r_leaf); last_cnt = int'(r_cnt); last_dep = int'(r_dep);
    end
    if (f_valid) begin
      if (q_ref.size() == 0) chk("R9 unexpected refresh row", int'(f_row), -1);
      else chk("R9 refresh row", int'(f_row), q_ref.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(a_ready), 1);
    chk("R1 no response after reset", int'(r_valid), 0);
    chk("R1 no refresh after reset", int'(f_valid), 0);

    acc(5); settle();
    chk("R1 root leaf", last_leaf, 0);
    chk("R1 root depth", last_dep, 0);
    chk("R1 first count", last_cnt, 1);

    repeat (3) acc(0);
    acc(0); settle();
    chk("R5 lower child depth", last_dep, 1);
    chk("R5 inherited count", last_cnt, 5);
    acc(32); settle();
    chk("R5 upper child index", last_leaf, 1);
    chk("R5 upper child count", last_cnt, 5);

    repeat (3) acc(0);
    acc(0); settle();
    chk("R8 count restarts after full", last_cnt, 1);

    repeat (19) acc(0);
    settle();
    chk("R6 depth capped", last_dep, MD);
    chk("R6 count at half", last_cnt, TH / 2);
    acc(0); settle();
    chk("R6 no split at max depth", last_cnt, TH / 2 + 1);

    repeat (20) acc(40);
    repeat (10) acc(50);
    settle();
    chk("R7 leaf kept when pool full", last_leaf, 4);
    chk("R7 depth kept when pool full", last_dep, 2);
    chk("R7 count past half", last_cnt, 6);

    iv_end = 1'b1; @(negedge clk); iv_end = 1'b0;
    model_reset();
    chk("R10 ready after interval end", int'(a_ready), 1);
    acc(50);
    chk("R2 ready low while busy", int'(a_ready), 0);
    settle();
    chk("R10 root leaf again", last_leaf, 0);
    chk("R10 root depth again", last_dep, 0);
    chk("R10 counts cleared", last_cnt, 1);

    repeat (5) @(negedge clk);
    chk("R2 all responses seen", q_leaf.size(), 0);
    chk("R9 all refresh rows seen", q_ref.size(), 0);
    finish_run();
  end
endmodule